// File: doc/BRIEF.md
# ATA Bus Access Sequencer

This block drives the shared ATA device bus for two kinds of traffic. The first kind is host-started programmed I/O (PIO) register and data cycles. The second kind is multiword-DMA bursts that only the drive can start. Software first writes one 8-bit cycle count for each bus phase. A PIO cycle then walks through three timed phases: an address setup, a strobe-active phase and a strobe-recovery phase. A DMA burst alternates a strobe-negated phase and a strobe-asserted phase while the DMA acknowledge is held. One word moves to or from a zero-wait-state FIFO port at every strobe rising edge.

The host may raise a PIO request at any time. If a burst is running, the request is held until the burst reaches a word boundary. The acknowledge is then released, the PIO cycle runs, and the burst resumes when the drive still requests it. All PIO modes 0 to 4 and multiword-DMA modes 0 to 2 are reached purely through the programmed counts.

Top module: `ata_bus_seq`

## Requirements
- R1: Out of reset, both chip selects, both strobes and the DMA acknowledge are negated (high), and `dev_doe`, `fifo_wr_en`, `fifo_rd_en` and `pio_done` are low.
- R2: A PIO cycle holds `pio_req`. The sequence is:
  - setup: chip select and address driven, strobes high, for the count at config address 0;
  - active: strobe low (`dev_rd_n` for a read, `dev_wr_n` for a write), for the count at address 1;
  - recovery: chip selects released, strobes high, for the count at address 2.
  - `pio_done` is high for one cycle, the last recovery cycle.
- R3: A programmed count of 0 behaves exactly like a count of 1.
- R4: A PIO read returns on `pio_rdata` the bus word present in the last active cycle. A PIO write drives `pio_wdata` on `dev_dout` with `dev_doe` high through setup and active.
- R5: Bit 3 of `pio_reg` picks the chip select: 1 gives `dev_cs_n`=2'b01, 0 gives 2'b10. Bits 2:0 appear on `dev_addr`.
- R6: Config address 5 is the control register, with bit 0 as the DMA enable and bit 1 as the direction (1 = drive to FIFO). A burst starts only when the enable is set and `dev_dreq` is high. With the enable clear, `dev_dreq` has no effect.
- R7: During a burst `dev_dack_n` stays low. The phases alternate:
  - strobe negated, for the count at address 4;
  - strobe asserted, for the count at address 3.
  - At each strobe rising edge exactly one word is pushed into the FIFO (`fifo_wdata` = `dev_din`) or popped from it (`dev_dout` = `fifo_rdata`).
- R8: Before each new strobe the burst re-checks `dev_dreq` and FIFO space (not full for reads, not empty for writes). If either check fails, the burst ends and the acknowledge is released.
- R9: A PIO request during a burst ends the burst at a word boundary. No DMA strobe is ever shortened, and no chip select is asserted while the acknowledge is low. The burst resumes afterwards if it is still requested.
- R10: When a PIO request and a DMA start are both possible in the idle state, the PIO cycle goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config register address |
| cfg_wdata | input | 8 | Config write data |
| pio_req | input | 1 | PIO request, held until done |
| pio_wr | input | 1 | PIO direction, 1 = write |
| pio_reg | input | 4 | Chip-select choice and device address |
| pio_wdata | input | 16 | PIO write data |
| pio_rdata | output | 16 | PIO read data |
| pio_done | output | 1 | PIO cycle completes this cycle |
| fifo_wr_en | output | 1 | Push to FIFO (device-to-FIFO burst) |
| fifo_wdata | output | 16 | Word pushed to FIFO |
| fifo_full | input | 1 | FIFO has no space |
| fifo_rd_en | output | 1 | Pop from FIFO (FIFO-to-device burst) |
| fifo_rdata | input | 16 | FIFO head word |
| fifo_empty | input | 1 | FIFO has no data |
| dev_cs_n | output | 2 | Chip selects, active low |
| dev_addr | output | 3 | Device register address |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 16 | Data driven to the device bus |
| dev_doe | output | 1 | Data output enable |
| dev_din | input | 16 | Data from the device bus |
| dev_dreq | input | 1 | DMA request from drive |
| dev_dack_n | output | 1 | DMA acknowledge, active low |

## Verification
Some properties are checked on every cycle:
- the two strobes are never low together;
- a chip select and the DMA acknowledge are never active at once;
- at most one chip select is active;
- no FIFO push happens into a full FIFO and no pop from an empty one;
- every acknowledge start follows a sampled request;
- the done pulse lasts a single cycle.

Other behaviour only the bench scenarios can show:
- exact phase lengths for many programmed counts, including 0 and 255;
- returned read data and written bus data;
- the word counts at which a burst stops;
- the correct ordering of a PIO cycle against a burst that is in flight, and the burst's resumption.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
    localparam int CFG_AW   = 3;
    localparam int DEV_AW   = 3;
    localparam int PREG_W   = DEV_AW + 1;
    localparam int NUM_TIME = 5;
    localparam int T_PSETUP = 0;
    localparam int T_PACT   = 1;
    localparam int T_PREC   = 2;
    localparam int T_DACT   = 3;
    localparam int T_DREC   = 4;
    localparam int A_CTRL   = 5;
    localparam int C_DMAEN  = 0;
    localparam int C_DMARD  = 1;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PSETUP  = 3'd1,
        ST_PACT    = 3'd2,
        ST_PREC    = 3'd3,
        ST_DNEG    = 3'd4,
        ST_DSTRB   = 3'd5
    } seq_state_e;
endpackage

// File: rtl/ata_cfg_regs.sv
module ata_cfg_regs
    import ata_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [CFG_AW-1:0]                  cfg_addr,
    input  logic [CNT_W-1:0]                   cfg_wdata,
    output logic [NUM_TIME-1:0][CNT_W-1:0]     tim_q,
    output logic                               dma_en_q,
    output logic                               dma_rd_q
);
    typedef struct packed {
        logic [NUM_TIME-1:0][CNT_W-1:0] tim;
        logic                           en;
        logic                           rd;
    } cfg_t;

    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_TIME; i++) begin
            if (cfg_we && cfg_addr == CFG_AW'(i)) begin
                r_d.tim[i] = cfg_wdata;
            end
        end
        if (cfg_we && cfg_addr == CFG_AW'(A_CTRL)) begin
            r_d.en = cfg_wdata[C_DMAEN];
            r_d.rd = cfg_wdata[C_DMARD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tim_q    = r_q.tim;
    assign dma_en_q = r_q.en;
    assign dma_rd_q = r_q.rd;
endmodule

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            // zero is clamped so that no phase is empty
            cnt_d = (load_len == '0) ? CNT_W'(1) : load_len;
        end else if (cnt_q > CNT_W'(1)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(1);
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ata_seq_fsm.sv
module ata_seq_fsm
    import ata_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_TIME-1:0][CNT_W-1:0] tim_q,
    input  logic                           dma_en,
    input  logic                           dma_rd,
    input  logic                           pio_req,
    input  logic                           pio_wr,
    input  logic                           dev_dreq,
    input  logic                           fifo_full,
    input  logic                           fifo_empty,
    input  logic [DATA_W-1:0]              dev_din,
    input  logic                           phase_last,
    output seq_state_e                     state_o,
    output logic                           phase_load,
    output logic [CNT_W-1:0]               phase_len,
    output logic                           word_xfer,
    output logic                           pio_done,
    output logic [DATA_W-1:0]              pio_rdata
);
    typedef struct packed {
        seq_state_e          state;
        logic [DATA_W-1:0]   rdata;
    } fsm_t;

    fsm_t s_d, s_q;
    logic fifo_ok, dma_go;

    always_comb begin
        s_d        = s_q;
        word_xfer  = 1'b0;
        pio_done   = 1'b0;
        phase_load = 1'b0;
        phase_len  = '0;
        fifo_ok    = dma_rd ? !fifo_full : !fifo_empty;
        dma_go     = dma_en && dev_dreq && fifo_ok;

        case (s_q.state)
            ST_IDLE: begin
                if (pio_req)     s_d.state = ST_PSETUP;
                else if (dma_go) s_d.state = ST_DNEG;
            end
            ST_PSETUP: begin
                if (phase_last) s_d.state = ST_PACT;
            end
            ST_PACT: begin
                if (phase_last) begin
                    s_d.state = ST_PREC;
                    if (!pio_wr) s_d.rdata = dev_din;
                end
            end
            ST_PREC: begin
                if (phase_last) begin
                    s_d.state = ST_IDLE;
                    pio_done  = 1'b1;
                end
            end
            ST_DNEG: begin
                if (phase_last) begin
                    s_d.state = (dma_go && !pio_req) ? ST_DSTRB : ST_IDLE;
                end
            end
            ST_DSTRB: begin
                if (phase_last) begin
                    word_xfer = 1'b1;
                    s_d.state = pio_req ? ST_IDLE : ST_DNEG;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        if (s_d.state != s_q.state) begin
            phase_load = 1'b1;
            case (s_d.state)
                ST_PSETUP: phase_len = tim_q[T_PSETUP];
                ST_PACT:   phase_len = tim_q[T_PACT];
                ST_PREC:   phase_len = tim_q[T_PREC];
                ST_DNEG:   phase_len = tim_q[T_DREC];
                ST_DSTRB:  phase_len = tim_q[T_DACT];
                default:   phase_len = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o   = s_q.state;
    assign pio_rdata = s_q.rdata;
endmodule

// File: rtl/ata_bus_drive.sv
module ata_bus_drive
    import ata_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  seq_state_e          state,
    input  logic                pio_wr,
    input  logic [PREG_W-1:0]   pio_reg,
    input  logic [DATA_W-1:0]   pio_wdata,
    input  logic [DATA_W-1:0]   fifo_rdata,
    input  logic [DATA_W-1:0]   dev_din,
    input  logic                dma_rd,
    input  logic                word_xfer,
    output logic [1:0]          dev_cs_n,
    output logic [DEV_AW-1:0]   dev_addr,
    output logic                dev_rd_n,
    output logic                dev_wr_n,
    output logic [DATA_W-1:0]   dev_dout,
    output logic                dev_doe,
    output logic                dev_dack_n,
    output logic                fifo_wr_en,
    output logic [DATA_W-1:0]   fifo_wdata,
    output logic                fifo_rd_en
);
    logic in_pio, sel_on, in_dma;

    always_comb begin
        in_pio = (state == ST_PSETUP) || (state == ST_PACT) || (state == ST_PREC);
        sel_on = (state == ST_PSETUP) || (state == ST_PACT);
        in_dma = (state == ST_DNEG) || (state == ST_DSTRB);

        dev_cs_n   = 2'b11;
        if (sel_on) dev_cs_n = pio_reg[DEV_AW] ? 2'b01 : 2'b10;
        dev_addr   = in_pio ? pio_reg[DEV_AW-1:0] : '0;
        dev_rd_n   = !(((state == ST_PACT) && !pio_wr) || ((state == ST_DSTRB) && dma_rd));
        dev_wr_n   = !(((state == ST_PACT) && pio_wr) || ((state == ST_DSTRB) && !dma_rd));
        dev_doe    = (sel_on && pio_wr) || (in_dma && !dma_rd);
        dev_dout   = in_pio ? pio_wdata : fifo_rdata;
        dev_dack_n = !in_dma;
        fifo_wr_en = word_xfer && dma_rd;
        fifo_rd_en = word_xfer && !dma_rd;
        fifo_wdata = dev_din;
    end
endmodule

// File: rtl/ata_bus_seq.sv
module ata_bus_seq
    import ata_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CNT_W-1:0]    cfg_wdata,
    input  logic                pio_req,
    input  logic                pio_wr,
    input  logic [PREG_W-1:0]   pio_reg,
    input  logic [DATA_W-1:0]   pio_wdata,
    output logic [DATA_W-1:0]   pio_rdata,
    output logic                pio_done,
    output logic                fifo_wr_en,
    output logic [DATA_W-1:0]   fifo_wdata,
    input  logic                fifo_full,
    output logic                fifo_rd_en,
    input  logic [DATA_W-1:0]   fifo_rdata,
    input  logic                fifo_empty,
    output logic [1:0]          dev_cs_n,
    output logic [DEV_AW-1:0]   dev_addr,
    output logic                dev_rd_n,
    output logic                dev_wr_n,
    output logic [DATA_W-1:0]   dev_dout,
    output logic                dev_doe,
    input  logic [DATA_W-1:0]   dev_din,
    input  logic                dev_dreq,
    output logic                dev_dack_n
);
    logic [NUM_TIME-1:0][CNT_W-1:0] tim_q;
    logic dma_en, dma_rd, phase_load, phase_last, word_xfer;
    logic [CNT_W-1:0] phase_len;
    seq_state_e state;

    ata_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tim_q(tim_q), .dma_en_q(dma_en), .dma_rd_q(dma_rd)
    );

    ata_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(phase_load), .load_len(phase_len),
        .last(phase_last)
    );

    ata_seq_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tim_q(tim_q), .dma_en(dma_en), .dma_rd(dma_rd),
        .pio_req(pio_req), .pio_wr(pio_wr), .dev_dreq(dev_dreq),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .dev_din(dev_din),
        .phase_last(phase_last), .state_o(state), .phase_load(phase_load),
        .phase_len(phase_len), .word_xfer(word_xfer), .pio_done(pio_done),
        .pio_rdata(pio_rdata)
    );

    ata_bus_drive #(.DATA_W(DATA_W)) u_drv (
        .state(state), .pio_wr(pio_wr), .pio_reg(pio_reg), .pio_wdata(pio_wdata),
        .fifo_rdata(fifo_rdata), .dev_din(dev_din), .dma_rd(dma_rd),
        .word_xfer(word_xfer), .dev_cs_n(dev_cs_n), .dev_addr(dev_addr),
        .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_dout(dev_dout),
        .dev_doe(dev_doe), .dev_dack_n(dev_dack_n), .fifo_wr_en(fifo_wr_en),
        .fifo_wdata(fifo_wdata), .fifo_rd_en(fifo_rd_en)
    );
endmodule

// File: rtl/ata_bus_seq_checker.sv
module ata_bus_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pio_done,
    input logic       fifo_wr_en,
    input logic       fifo_rd_en,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic [1:0] dev_cs_n,
    input logic       dev_rd_n,
    input logic       dev_wr_n,
    input logic       dev_dreq,
    input logic       dev_dack_n
);
    // R7: the two strobes never overlap
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_n || dev_wr_n);

    // R7: a strobe belongs either to a PIO select or to a DMA acknowledge
    p_strobe_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> (!dev_dack_n || dev_cs_n != 2'b11));

    // R7: the strobe is released right after a push
    p_push_then_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |=> dev_rd_n);

    // R9: chip selects never active while acknowledge is low
    p_cs_dack_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_cs_n != 2'b11) |-> dev_dack_n);

    // R5: at most one chip select active
    p_cs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dev_cs_n));

    // R6: acknowledge only starts after a sampled request
    p_dack_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_dack_n) |-> $past(dev_dreq));

    // R8: never push into a full FIFO or pop from an empty one
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !fifo_full);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);

    // R2: completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pio_done |=> !pio_done);
endmodule

bind ata_bus_seq ata_bus_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pio_done(pio_done), .fifo_wr_en(fifo_wr_en),
    .fifo_rd_en(fifo_rd_en), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_dreq(dev_dreq), .dev_dack_n(dev_dack_n)
);

// File: tb/ata_bus_seq_test.sv
`timescale 1ns/1ps
module ata_bus_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        pio_req = 1'b0;
    logic        pio_wr = 1'b0;
    logic [3:0]  pio_reg = '0;
    logic [15:0] pio_wdata = '0;
    logic [15:0] pio_rdata;
    logic        pio_done;
    logic        fifo_wr_en, fifo_rd_en, fifo_full, fifo_empty;
    logic [15:0] fifo_wdata, fifo_rdata;
    logic [1:0]  dev_cs_n;
    logic [2:0]  dev_addr;
    logic        dev_rd_n, dev_wr_n, dev_doe, dev_dreq, dev_dack_n;
    logic [15:0] dev_dout, dev_din;

    int checks = 0, fails = 0;
    int pushes = 0, pops = 0, push_base = 0, pop_base = 0;
    int rd_cap = 0, wr_avail = 0, stop_at = 0;
    logic dreq_drv = 1'b0;
    logic [15:0] pio_bus_val = '0;
    logic [15:0] last_push = '0, last_wdata = '0;
    int overlap_err = 0, runlen_err = 0, strobes = 0, run = 0, exp_dact = 1, dack_cycles = 0;

    always #10 clk = ~clk;

    ata_bus_seq uut (.*);

    assign fifo_full  = ((pushes - push_base) >= rd_cap);
    assign fifo_empty = ((pops - pop_base) >= wr_avail);
    assign fifo_rdata = 16'hB000 + 16'(pops);
    assign dev_din    = dev_dack_n ? pio_bus_val : (16'hA000 + 16'(pushes));
    assign dev_dreq   = dreq_drv && !(stop_at != 0 && pushes >= stop_at);

    always @(posedge clk) begin
        if (fifo_wr_en) begin pushes <= pushes + 1; last_push <= fifo_wdata; end
        if (fifo_rd_en) pops <= pops + 1;
    end

    always @(negedge clk) begin
        if (dev_cs_n != 2'b11 && !dev_dack_n) overlap_err++;
        if (!dev_dack_n) dack_cycles++;
        if (!dev_dack_n && (!dev_rd_n || !dev_wr_n)) begin
            run++;
            if (!dev_wr_n) last_wdata = dev_dout;
        end else begin
            if (run != 0) begin
                if (run != exp_dact) runlen_err++;
                strobes++;
            end
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pio_op(input logic wr, input logic [3:0] rg, input logic [15:0] wd,
                          input bit raise_dreq,
                          output int s, output int a, output int r, output logic [15:0] rd,
                          output logic [1:0] cs_seen, output logic [2:0] da_seen,
                          output logic [15:0] bus_seen);
        bit seen = 0;
        bit ok = 0;
        s = 0; a = 0; r = 0; cs_seen = 2'b11; da_seen = '0; bus_seen = 16'hDEAD;
        @(negedge clk);
        pio_req = 1'b1; pio_wr = wr; pio_reg = rg; pio_wdata = wd;
        if (raise_dreq) dreq_drv = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ((!dev_rd_n || !dev_wr_n) && dev_cs_n != 2'b11) begin
                a++; seen = 1; cs_seen = dev_cs_n; da_seen = dev_addr;
                bus_seen = dev_doe ? dev_dout : 16'hDEAD;
            end else if (!seen && dev_cs_n != 2'b11) s++;
            else if (seen && dev_dack_n) r++;
            if (pio_done) begin ok = 1; break; end
        end
        pio_req = 1'b0;
        rd = pio_rdata;
        chk(ok, "R2 pio completion", int'(ok), 1);
    endtask

    // {setup, active, recovery, write, reg, data}
    localparam logic [44:0] VEC [6] = '{
        {8'd3,   8'd4, 8'd2, 1'b0, 4'h7, 16'hA5A5},
        {8'd1,   8'd1, 8'd1, 1'b1, 4'hE, 16'h1234},
        {8'd0,   8'd0, 8'd0, 1'b0, 4'h0, 16'h0F0F},
        {8'd5,   8'd2, 8'd7, 1'b1, 4'h3, 16'hBEEF},
        {8'd255, 8'd3, 8'd1, 1'b0, 4'h9, 16'h7E81},
        {8'd2,   8'd9, 8'd0, 1'b1, 4'hC, 16'h5555}
    };

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int s, a, r, base, d0;
        logic [15:0] rd, bus;
        logic [1:0] cs;
        logic [2:0] da;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dev_cs_n == 2'b11 && dev_rd_n && dev_wr_n && dev_dack_n && !dev_doe &&
            !fifo_wr_en && !fifo_rd_en && !pio_done, "R1 reset outputs",
            {dev_cs_n, dev_rd_n, dev_wr_n, dev_dack_n, dev_doe}, 6'b111110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_cs_n == 2'b11 && dev_dack_n && !dev_doe, "R1 after reset",
            {dev_cs_n, dev_dack_n, dev_doe}, 4'b1110);

        // table of PIO cycles: R2 R3 R4 R5
        foreach (VEC[i]) begin
            logic [44:0] v = VEC[i];
            int es = (v[44:37] == 0) ? 1 : int'(v[44:37]);
            int ea = (v[36:29] == 0) ? 1 : int'(v[36:29]);
            int er = (v[28:21] == 0) ? 1 : int'(v[28:21]);
            cfg_write(3'd0, v[44:37]);
            cfg_write(3'd1, v[36:29]);
            cfg_write(3'd2, v[28:21]);
            pio_bus_val = v[15:0];
            pio_op(v[20], v[19:16], v[15:0], 1'b0, s, a, r, rd, cs, da, bus);
            chk(s == es, "R2/R3 setup cycles", s, es);
            chk(a == ea, "R2/R3 active cycles", a, ea);
            chk(r == er, "R2/R3 recovery cycles", r, er);
            chk(cs == (v[19] ? 2'b01 : 2'b10) && da == v[18:16], "R5 select and address",
                {cs, da}, {(v[19] ? 2'b01 : 2'b10), v[18:16]});
            if (v[20]) chk(bus == v[15:0], "R4 write data on bus", bus, v[15:0]);
            else       chk(rd == v[15:0], "R4 read data returned", rd, v[15:0]);
        end

        cfg_write(3'd0, 8'd2); cfg_write(3'd1, 8'd2); cfg_write(3'd2, 8'd2);
        cfg_write(3'd3, 8'd3); cfg_write(3'd4, 8'd2);
        exp_dact = 3;

        // R6: request ignored while disabled
        cfg_write(3'd5, 8'h02);
        push_base = pushes; rd_cap = 100; d0 = dack_cycles;
        dreq_drv = 1'b1;
        repeat (40) @(negedge clk);
        chk(dack_cycles == d0, "R6 no acknowledge when disabled", dack_cycles - d0, 0);
        chk(pushes == push_base, "R6 no words when disabled", pushes - push_base, 0);
        dreq_drv = 1'b0;

        // R7 R8: device-to-FIFO burst stops on full
        push_base = pushes; rd_cap = 4;
        dreq_drv = 1'b1;
        cfg_write(3'd5, 8'h03);
        repeat (80) @(negedge clk);
        chk(pushes - push_base == 4, "R8 burst stops at full", pushes - push_base, 4);
        chk(last_push == 16'hA000 + 16'(pushes - 1), "R7 pushed word from bus",
            last_push, 16'hA000 + 16'(pushes - 1));
        chk(runlen_err == 0, "R7 strobe length", runlen_err, 0);
        chk(dev_dack_n, "R8 acknowledge released at full", int'(dev_dack_n), 1);
        dreq_drv = 1'b0;

        // R8: burst stops when request drops
        repeat (5) @(negedge clk);
        push_base = pushes; rd_cap = 100; stop_at = pushes + 3;
        dreq_drv = 1'b1;
        repeat (80) @(negedge clk);
        chk(pushes - push_base == 3, "R8 burst stops on request drop", pushes - push_base, 3);
        chk(dev_dack_n, "R8 acknowledge released on drop", int'(dev_dack_n), 1);
        dreq_drv = 1'b0; stop_at = 0;

        // R7 R8: FIFO-to-device burst stops on empty
        cfg_write(3'd5, 8'h01);
        pop_base = pops; wr_avail = 5; base = strobes;
        dreq_drv = 1'b1;
        repeat (80) @(negedge clk);
        chk(pops - pop_base == 5, "R8 write burst stops at empty", pops - pop_base, 5);
        chk(strobes - base == 5, "R7 one strobe per word", strobes - base, 5);
        chk(last_wdata == 16'hB000 + 16'(pops - 1), "R7 FIFO word on bus",
            last_wdata, 16'hB000 + 16'(pops - 1));
        dreq_drv = 1'b0;

        // R10: PIO first when both start together
        cfg_write(3'd5, 8'h03);
        push_base = pushes; rd_cap = 1000; base = pushes;
        pio_bus_val = 16'h3C3C;
        pio_op(1'b0, 4'h1, 16'h0, 1'b1, s, a, r, rd, cs, da, bus);
        chk(pushes == base, "R10 PIO before DMA", pushes - base, 0);
        repeat (30) @(negedge clk);
        chk(pushes > base, "R9 burst starts after PIO", pushes - base, 1);

        // R9: PIO during a running burst
        pio_bus_val = 16'h6D6D; base = pushes;
        pio_op(1'b0, 4'h5, 16'h0, 1'b0, s, a, r, rd, cs, da, bus);
        chk(rd == 16'h6D6D, "R9 PIO read mid-burst", rd, 16'h6D6D);
        chk(a == 2, "R9 PIO active length mid-burst", a, 2);
        base = pushes;
        repeat (30) @(negedge clk);
        chk(pushes > base, "R9 burst resumes", pushes - base, 1);
        chk(overlap_err == 0, "R9 select and acknowledge apart", overlap_err, 0);
        chk(runlen_err == 0, "R9 no shortened strobe", runlen_err, 0);
        dreq_drv = 1'b0;
        repeat (20) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule